// File: doc/BRIEF.md
# Embedded Controller Host Handshake Port

This block is the device side of a two-port host interface on an embedded controller. The host talks to it through byte-wide strobed I/O cycles and a one-bit port select. Select 0 is the data port. Select 1 reads a status byte and, when written, takes a command byte. Two flags carry the handshake. The input flag says a host byte is still waiting to be taken by the device. The output flag says a byte is ready for the host to read.

The device side takes each host byte after a configurable number of cycles. It tells commands from data by the port the byte arrived on. It then steps through multi-byte sequences. A read sequence is one address byte, followed by a reply byte from the internal register space. A write sequence is an address byte followed by a data byte. The block also handles burst-mode enable and disable and a query command. The register space holds 256 bytes. It resets to zero, except for one preloaded location.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 and the data port reads 0x00.
- R2: Status bit layout: bit 0 is the output flag, bit 1 the input flag, bit 3 is set when the last accepted host write went to the command port (select 1), bit 4 is burst mode, and bits 2, 5, 6 and 7 read 0.
- R3: An accepted host write sets the input flag and updates bit 3 on the next cycle. The input flag then stays set for exactly LATENCY cycles in total, and clears in the cycle the byte is consumed.
- R4: A host write that arrives while the input flag is set is dropped. The flag timing, bit 3 and the sequence state are unaffected.
- R5: A host read strobe on the data port clears the output flag on the next cycle. A read strobe on the status port leaves it unchanged.
- R6: Command 0x80 followed by an address byte on the data port places the addressed register's byte in the data port and sets the output flag when the address byte is consumed.
- R7: Command 0x81 followed by an address byte and then a data byte stores that data byte at that address.
- R8: Command 0x82 sets status bit 4 and answers 0x90 with the output flag set. Command 0x83 clears bit 4 and sets no output flag.
- R9: Command 0x84 answers 0x00 with the output flag set.
- R10: Any other command value is ignored and returns the sequencer to idle. A data byte received in idle is ignored. A command that arrives in the middle of a sequence abandons that sequence.
- R11: After reset every register reads 0x00, except address PRESET_ADDR, which reads PRESET_VAL (0x80 at address 0x01 by default).
- R12: If a host data-port read and a device reply load fall in the same cycle, the read returns the previous byte and the output flag stays set with the new reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_stb | input | 1 | Host access strobe, one cycle per access |
| io_wr | input | 1 | 1 for a host write, 0 for a host read |
| io_sel | input | 1 | 0 selects the data port, 1 the status/command port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte: status when io_sel is 1, data register otherwise |

## Verification
The output flag has two owners. The host clears it by reading the data port, and the device sets it when it posts a reply. Both can act in the same cycle. The bench sets up this case as follows. It leaves a burst acknowledge unread, issues a query, and then times a data-port read strobe so that it lands on the exact cycle the query is consumed, which is LATENCY cycles after the command write. The read must return the old acknowledge byte. The status must still show the output flag afterwards, and a second read must return the query reply.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_RD_ADDR = 2'd1,
    SQ_WR_ADDR = 2'd2,
    SQ_WR_DATA = 2'd3
  } seq_state_e;

  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;

  localparam logic [7:0] REPLY_BURST_ACK = 8'h90;
  localparam logic [7:0] REPLY_NO_EVENT  = 8'h00;

  localparam int ST_OUT_FULL = 0;
  localparam int ST_IN_FULL  = 1;
  localparam int ST_WAS_CMD  = 3;
  localparam int ST_BURST    = 4;

endpackage

// File: rtl/ec_host_if.sv
module ec_host_if #(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_stb,
  input  logic       io_wr,
  input  logic       io_sel,
  input  logic [7:0] io_wdata,
  input  logic       load_out,
  input  logic [7:0] load_byte,
  output logic       in_full,
  output logic       was_cmd,
  output logic       consume,
  output logic [7:0] in_byte,
  output logic       out_full,
  output logic [7:0] out_byte
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  logic             in_full_q, in_full_d;
  logic             was_cmd_q, was_cmd_d;
  logic [7:0]       in_byte_q, in_byte_d;
  logic [CNT_W-1:0] wait_q, wait_d;
  logic             out_full_q, out_full_d;
  logic [7:0]       out_byte_q, out_byte_d;
  logic             accept;
  logic             host_rd_data;

  assign accept       = io_stb & io_wr & ~in_full_q;
  assign host_rd_data = io_stb & ~io_wr & ~io_sel;
  assign consume      = in_full_q & (wait_q == CNT_W'(1));

  always_comb begin
    in_full_d = in_full_q;
    was_cmd_d = was_cmd_q;
    in_byte_d = in_byte_q;
    wait_d    = wait_q;
    if (accept) begin
      in_full_d = 1'b1;
      was_cmd_d = io_sel;
      in_byte_d = io_wdata;
      wait_d    = CNT_W'(LATENCY);
    end else if (consume) begin
      in_full_d = 1'b0;
      wait_d    = '0;
    end else if (in_full_q) begin
      wait_d    = wait_q - CNT_W'(1);
    end
  end

  always_comb begin
    out_full_d = out_full_q;
    out_byte_d = out_byte_q;
    if (load_out) begin
      out_full_d = 1'b1;
      out_byte_d = load_byte;
    end else if (host_rd_data) begin
      out_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full_q  <= 1'b0;
      was_cmd_q  <= 1'b0;
      in_byte_q  <= '0;
      wait_q     <= '0;
      out_full_q <= 1'b0;
      out_byte_q <= '0;
    end else begin
      in_full_q  <= in_full_d;
      was_cmd_q  <= was_cmd_d;
      in_byte_q  <= in_byte_d;
      wait_q     <= wait_d;
      out_full_q <= out_full_d;
      out_byte_q <= out_byte_d;
    end
  end

  assign in_full  = in_full_q;
  assign was_cmd  = was_cmd_q;
  assign in_byte  = in_byte_q;
  assign out_full = out_full_q;
  assign out_byte = out_byte_q;

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
  import ec_host_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic              is_cmd,
  input  logic [7:0]        in_byte,
  input  logic [7:0]        mem_rdata,
  output logic              load_out,
  output logic [7:0]        load_byte,
  output logic              burst,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [7:0]        mem_wdata
);

  seq_state_e        state_q, state_d;
  logic              burst_q, burst_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign mem_raddr = in_byte[ADDR_W-1:0];
  assign mem_waddr = addr_q;
  assign mem_wdata = in_byte;

  always_comb begin
    state_d   = state_q;
    burst_d   = burst_q;
    addr_d    = addr_q;
    load_out  = 1'b0;
    load_byte = '0;
    mem_we    = 1'b0;
    if (consume) begin
      if (is_cmd) begin
        state_d = SQ_IDLE;
        case (in_byte)
          OP_READ:      state_d = SQ_RD_ADDR;
          OP_WRITE:     state_d = SQ_WR_ADDR;
          OP_BURST_ON: begin
            burst_d   = 1'b1;
            load_out  = 1'b1;
            load_byte = REPLY_BURST_ACK;
          end
          OP_BURST_OFF: burst_d = 1'b0;
          OP_QUERY: begin
            load_out  = 1'b1;
            load_byte = REPLY_NO_EVENT;
          end
          default: ;
        endcase
      end else begin
        case (state_q)
          SQ_RD_ADDR: begin
            load_out  = 1'b1;
            load_byte = mem_rdata;
            state_d   = SQ_IDLE;
          end
          SQ_WR_ADDR: begin
            addr_d  = in_byte[ADDR_W-1:0];
            state_d = SQ_WR_DATA;
          end
          SQ_WR_DATA: begin
            mem_we  = 1'b1;
            state_d = SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      burst_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      burst_q <= burst_d;
      addr_q  <= addr_d;
    end
  end

  assign burst = burst_q;

endmodule

// File: rtl/ec_regspace.sv
module ec_regspace #(
  parameter int         ADDR_W      = 8,
  parameter int         PRESET_ADDR = 1,
  parameter logic [7:0] PRESET_VAL  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cell_q[i] <= (i == PRESET_ADDR) ? PRESET_VAL : 8'h00;
      end
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_host_pkg::*;
#(
  parameter int         LATENCY     = 3,
  parameter int         ADDR_W      = 8,
  parameter int         PRESET_ADDR = 1,
  parameter logic [7:0] PRESET_VAL  = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_stb,
  input  logic       io_wr,
  input  logic       io_sel,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata
);

  logic              in_full, was_cmd, consume, out_full, burst;
  logic [7:0]        in_byte, out_byte, load_byte, mem_rdata, mem_wdata;
  logic              load_out, mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        status;

  ec_host_if #(.LATENCY(LATENCY)) host_if_i (
    .clk(clk), .rst_n(rst_n),
    .io_stb(io_stb), .io_wr(io_wr), .io_sel(io_sel), .io_wdata(io_wdata),
    .load_out(load_out), .load_byte(load_byte),
    .in_full(in_full), .was_cmd(was_cmd), .consume(consume),
    .in_byte(in_byte), .out_full(out_full), .out_byte(out_byte)
  );

  ec_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .consume(consume), .is_cmd(was_cmd), .in_byte(in_byte),
    .mem_rdata(mem_rdata),
    .load_out(load_out), .load_byte(load_byte), .burst(burst),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
    .mem_wdata(mem_wdata)
  );

  ec_regspace #(
    .ADDR_W(ADDR_W), .PRESET_ADDR(PRESET_ADDR), .PRESET_VAL(PRESET_VAL)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  always_comb begin
    status              = 8'h00;
    status[ST_OUT_FULL] = out_full;
    status[ST_IN_FULL]  = in_full;
    status[ST_WAS_CMD]  = was_cmd;
    status[ST_BURST]    = burst;
  end

  assign io_rdata = io_sel ? status : out_byte;

endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
  parameter int LATENCY = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_stb,
  input logic       io_wr,
  input logic       io_sel,
  input logic [7:0] status
);

  logic [15:0] held_q;
  logic        taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                held_q <= '0;
    else if (io_stb && io_wr && !status[1])    held_q <= 16'd1;
    else if (status[1])                        held_q <= held_q + 16'd1;
  end

  assign taken = status[1] && (held_q == 16'(LATENCY));

  p_write_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb && io_wr && !status[1] |=> status[1] && (status[3] == $past(io_sel)));

  p_flag_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && (held_q < 16'(LATENCY)) |=> status[1]);

  p_flag_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !status[1]);

  p_busy_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb && io_wr && status[1] && !taken |=> status[1] && $stable(status[3]));

  p_data_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb && !io_wr && !io_sel && !taken |=> !status[0]);

  p_out_set_only_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] && !taken |=> !status[0]);

  p_burst_only_on_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> $stable(status[4]));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'hE4) == 8'h00);

endmodule

bind ec_host_port ec_host_port_chk #(.LATENCY(LATENCY)) chk_i (
  .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_wr(io_wr),
  .io_sel(io_sel), .status(status)
);

// File: tb/ec_host_port_tb_top.sv
module ec_host_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_stb, io_wr, io_sel;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  int         n_chk  = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ec_host_port #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_wr(io_wr),
    .io_sel(io_sel), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek_status(output logic [7:0] s);
    io_sel = 1'b1; #1; s = io_rdata;
  endtask

  task automatic peek_data(output logic [7:0] d);
    io_sel = 1'b0; #1; d = io_rdata;
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] b);
    io_stb = 1'b1; io_wr = 1'b1; io_sel = sel; io_wdata = b;
    @(negedge clk);
    io_stb = 1'b0; io_wr = 1'b0;
  endtask

  task automatic host_rd(input logic sel, output logic [7:0] d);
    io_stb = 1'b1; io_wr = 1'b0; io_sel = sel;
    #1; d = io_rdata;
    @(negedge clk);
    io_stb = 1'b0;
  endtask

  task automatic wait_taken();
    logic [7:0] s;
    peek_status(s);
    while (s[1]) begin
      @(negedge clk);
      peek_status(s);
    end
  endtask

  task automatic send(input logic sel, input logic [7:0] b);
    host_wr(sel, b);
    wait_taken();
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] s;
    send(1'b1, 8'h80);
    send(1'b0, a);
    peek_status(s);
    chk("R6 out flag after address", s & 8'h01, 8'h01);
    host_rd(1'b0, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek_status(v); chk("R1 status after reset", v, 8'h00);
    peek_data(v);   chk("R1 data after reset", v, 8'h00);
  endtask

  task automatic t_flag_timing();
    logic [7:0] s;
    host_wr(1'b1, 8'h83);
    peek_status(s); chk("R3 R2 status right after command write", s, 8'h0A);
    for (int i = 0; i < LAT - 1; i++) begin
      @(negedge clk);
      peek_status(s); chk("R3 input flag still held", s, 8'h0A);
    end
    @(negedge clk);
    peek_status(s); chk("R3 input flag cleared after LATENCY", s, 8'h08);
    host_wr(1'b0, 8'h00);
    peek_status(s); chk("R3 bit 3 follows data-port write", s, 8'h02);
    wait_taken();
    peek_status(s); chk("R10 data byte in idle ignored", s, 8'h00);
  endtask

  task automatic t_drop();
    logic [7:0] s, d;
    host_wr(1'b1, 8'h80);
    host_wr(1'b0, 8'h01);
    peek_status(s); chk("R4 busy write leaves bit 3", s, 8'h0A);
    wait_taken();
    peek_status(s); chk("R4 dropped byte not used as address", s, 8'h08);
    send(1'b0, 8'h01);
    peek_status(s); chk("R4 sequence still waits for address", s & 8'h01, 8'h01);
    host_rd(1'b0, d); chk("R11 preset register value", d, 8'h80);
  endtask

  task automatic t_read_write();
    logic [7:0] d;
    reg_read(8'h02, d); chk("R11 other register reset to zero", d, 8'h00);
    send(1'b1, 8'h81); send(1'b0, 8'h20); send(1'b0, 8'hA5);
    send(1'b1, 8'h81); send(1'b0, 8'hFF); send(1'b0, 8'h3C);
    reg_read(8'h20, d); chk("R7 R6 readback 0x20", d, 8'hA5);
    reg_read(8'hFF, d); chk("R7 R6 readback 0xFF", d, 8'h3C);
    reg_read(8'h21, d); chk("R7 neighbour untouched", d, 8'h00);
  endtask

  task automatic t_out_read();
    logic [7:0] s, d;
    send(1'b1, 8'h84);
    host_rd(1'b1, s); chk("R5 status read returns flag", s & 8'h01, 8'h01);
    peek_status(s); chk("R5 status read keeps out flag", s & 8'h01, 8'h01);
    host_rd(1'b0, d); chk("R9 query reply", d, 8'h00);
    peek_status(s); chk("R5 data read clears out flag", s & 8'h01, 8'h00);
  endtask

  task automatic t_burst();
    logic [7:0] s, d;
    send(1'b1, 8'h82);
    peek_status(s); chk("R8 burst on status", s, 8'h19);
    host_rd(1'b0, d); chk("R8 burst acknowledge byte", d, 8'h90);
    peek_status(s); chk("R8 status after ack read", s, 8'h18);
    send(1'b1, 8'h83);
    peek_status(s); chk("R8 burst off status, no reply", s, 8'h08);
  endtask

  task automatic t_ignore();
    logic [7:0] s, d;
    send(1'b1, 8'h55);
    send(1'b0, 8'h01);
    peek_status(s); chk("R10 unknown command ignored", s, 8'h00);
    send(1'b1, 8'h81); send(1'b0, 8'h30);
    send(1'b1, 8'h84);
    peek_status(s); chk("R10 command aborts write sequence", s, 8'h09);
    host_rd(1'b0, d); chk("R9 query reply after abort", d, 8'h00);
    send(1'b0, 8'h77);
    peek_status(s); chk("R10 stray data after abort ignored", s, 8'h00);
    reg_read(8'h30, d); chk("R10 aborted write not stored", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] s, d;
    send(1'b1, 8'h82);
    host_wr(1'b1, 8'h84);
    for (int i = 0; i < LAT - 1; i++) @(negedge clk);
    host_rd(1'b0, d); chk("R12 same-cycle read gets old byte", d, 8'h90);
    peek_status(s); chk("R12 out flag kept by new reply", s, 8'h19);
    host_rd(1'b0, d); chk("R12 new reply present", d, 8'h00);
    send(1'b1, 8'h83);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_stb = 1'b0; io_wr = 1'b0; io_sel = 1'b0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flag_timing();
    t_drop();
    t_read_write();
    t_out_read();
    t_burst();
    t_ignore();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule